// File: doc/BRIEF.md
# SPI Command Instruction Sequencer

This block runs a stream of 16-bit instructions, one after another, on behalf of a serial-peripheral shift engine. Each word arriving on a valid/ready command input is decoded into one of four actions. It can start a transfer on the shift engine and wait for that transfer to finish. It can drive the eight active-low chip-select lines, optionally followed by a hold time. It can write one of three configuration registers: clock divider, mode and bits per word. Its last action is a misc operation, which is either a sleep for a number of serial-clock ticks or a sync event that publishes an 8-bit ID.

An instruction word has a 4-bit opcode in bits [15:12], a 4-bit first argument in bits [11:8] and an 8-bit second argument in bits [7:0]. One serial-clock tick lasts 2*(D+1) system clock cycles, where D is the current clock-divider register value. Sleeps and chip-select hold times are timed in these ticks. The block accepts a new instruction only when the previous one has fully completed, so a host fills a queue in front of it and a sync ID at the end of the program marks completion.

Top module: `spi_cmd_seq`

## Requirements
- R1: During and after reset, cs_n is 8'hFF, cmd_ready is 1, all three configuration outputs and sync_id are 0, and xfer_start and sync_pulse are 0.
- R2: An accepted opcode 0 raises xfer_start for exactly one cycle, the cycle after acceptance. In that cycle xfer_flags equals bits [9:8] (bit 0 write, bit 1 read) and xfer_words_m1 equals bits [7:0].
- R3: After an opcode 0, cmd_ready stays 0 until xfer_done is sampled high, and it is 1 again in the cycle after that sample.
- R4: An accepted opcode 1 drives bits [7:0] onto cs_n in the cycle after acceptance; cs_n changes on no other instruction.
- R5: For opcode 1, a nonzero bits [11:8] value H holds cmd_ready at 0 for exactly H*2*(D+1) cycles after acceptance; H = 0 causes no stall.
- R6: An accepted opcode 2 with bits [11:8] = 0, 1 or 2 loads bits [7:0] into cfg_clk_div, cfg_mode or cfg_word_bits respectively, visible the cycle after acceptance.
- R7: An accepted opcode 3 with bits [11:8] = 1 holds cmd_ready at 0 for exactly (N+1)*2*(D+1) cycles, where N is bits [7:0].
- R8: An accepted opcode 3 with bits [11:8] = 0 loads bits [7:0] into sync_id and raises sync_pulse for exactly one cycle, the cycle after acceptance.
- R9: Opcodes 4 to 15, opcode 2 with a select of 3 to 15, and opcode 3 with a select of 2 to 15 are accepted without a stall. They change no output: no start pulse, no sync pulse, and cs_n, the configuration outputs and sync_id stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Instruction word present |
| cmd_data | input | 16 | Instruction word |
| cmd_ready | output | 1 | Sequencer can take an instruction |
| xfer_start | output | 1 | One-cycle start request to the shift engine |
| xfer_flags | output | 2 | Transfer direction flags (bit 0 write, bit 1 read) |
| xfer_words_m1 | output | 8 | Transfer word count minus one |
| xfer_done | input | 1 | Shift engine finished the current transfer |
| cs_n | output | 8 | Active-low chip-select lines |
| cfg_clk_div | output | 8 | Clock divider register |
| cfg_mode | output | 8 | Mode configuration register |
| cfg_word_bits | output | 8 | Bits-per-word register |
| sync_pulse | output | 1 | One-cycle sync event |
| sync_id | output | 8 | ID of the last sync instruction |

## Verification
Every register-type result lands one cycle after the accepting edge: cs_n, the configuration outputs, sync_id, the start and sync pulses, and the transfer fields. The bench therefore samples all of them on the falling edge that directly follows acceptance. Stall lengths are measured by counting falling edges with cmd_ready low, starting at that same falling edge, and compared with H*2*(D+1) or (N+1)*2*(D+1). For a transfer, xfer_done is raised for one cycle, and cmd_ready is expected back on the falling edge after the edge that sampled it.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int OP_W   = 4;
    localparam int ARG1_W = 4;
    localparam int ARG2_W = 8;
    localparam int INSTR_W = OP_W + ARG1_W + ARG2_W;
    localparam int CNT_W  = ARG2_W + 1;
    localparam int NUM_CFG = 3;

    localparam logic [OP_W-1:0] OP_XFER = 4'd0;
    localparam logic [OP_W-1:0] OP_CS   = 4'd1;
    localparam logic [OP_W-1:0] OP_REG  = 4'd2;
    localparam logic [OP_W-1:0] OP_MISC = 4'd3;

    localparam logic [ARG1_W-1:0] SEL_DIV  = 4'd0;
    localparam logic [ARG1_W-1:0] SEL_MODE = 4'd1;
    localparam logic [ARG1_W-1:0] SEL_BITS = 4'd2;

    localparam logic [ARG1_W-1:0] MISC_SYNC  = 4'd0;
    localparam logic [ARG1_W-1:0] MISC_SLEEP = 4'd1;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ARG1_W-1:0] a1;
        logic [ARG2_W-1:0] a2;
    } seq_instr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    // Last count of one serial tick: a tick spans 2*(div+1) cycles.
    function automatic logic [ARG2_W:0] tick_last(input logic [ARG2_W-1:0] div);
        return {div, 1'b1};
    endfunction

endpackage

// File: rtl/seq_cfg_bank.sv
module seq_cfg_bank
    import spi_seq_pkg::*;
#(
    parameter int NUM = NUM_CFG,
    parameter int W   = ARG2_W,
    parameter int SEL_W = ARG1_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [W-1:0]            wr_val,
    output logic [NUM-1:0][W-1:0]   regs
);

    for (genvar i = 0; i < NUM; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                regs[i] <= wr_val;
            end
        end
    end

    // R6: registers move only on a write
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

endmodule

// File: rtl/seq_tick_gen.sv
module seq_tick_gen
    import spi_seq_pkg::*;
#(
    parameter int DIV_W = ARG2_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = {div, 1'b1};
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: a tick lasts at least two cycles, so no back-to-back ticks
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [INSTR_W-1:0] cmd_data,
    output logic               cmd_ready,
    output logic               xfer_start,
    output logic [1:0]         xfer_flags,
    output logic [ARG2_W-1:0]  xfer_words_m1,
    input  logic               xfer_done,
    output logic [ARG2_W-1:0]  cs_n,
    output logic [ARG2_W-1:0]  cfg_clk_div,
    output logic [ARG2_W-1:0]  cfg_mode,
    output logic [ARG2_W-1:0]  cfg_word_bits,
    output logic               sync_pulse,
    output logic [ARG2_W-1:0]  sync_id
);

    seq_state_e state;
    seq_instr_t instr;
    logic       accept;
    logic       tick;
    logic [CNT_W-1:0] remaining;
    logic [NUM_CFG-1:0][ARG2_W-1:0] cfg;

    assign instr     = seq_instr_t'(cmd_data);
    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    seq_cfg_bank #(.NUM(NUM_CFG), .W(ARG2_W), .SEL_W(ARG1_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (accept && (instr.op == OP_REG)),
        .wr_sel (instr.a1),
        .wr_val (instr.a2),
        .regs   (cfg)
    );

    assign cfg_clk_div   = cfg[SEL_DIV];
    assign cfg_mode      = cfg[SEL_MODE];
    assign cfg_word_bits = cfg[SEL_BITS];

    seq_tick_gen #(.DIV_W(ARG2_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_WAIT),
        .div  (cfg_clk_div),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cs_n          <= '1;
            xfer_start    <= 1'b0;
            xfer_flags    <= '0;
            xfer_words_m1 <= '0;
            sync_pulse    <= 1'b0;
            sync_id       <= '0;
            remaining     <= '0;
        end else begin
            xfer_start <= 1'b0;
            sync_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        case (instr.op)
                            OP_XFER: begin
                                xfer_start    <= 1'b1;
                                xfer_flags    <= instr.a1[1:0];
                                xfer_words_m1 <= instr.a2;
                                state         <= ST_XFER;
                            end
                            OP_CS: begin
                                cs_n <= instr.a2;
                                if (instr.a1 != '0) begin
                                    remaining <= CNT_W'(instr.a1);
                                    state     <= ST_WAIT;
                                end
                            end
                            OP_MISC: begin
                                if (instr.a1 == MISC_SLEEP) begin
                                    remaining <= {1'b0, instr.a2} + 1'b1;
                                    state     <= ST_WAIT;
                                end else if (instr.a1 == MISC_SYNC) begin
                                    sync_id    <= instr.a2;
                                    sync_pulse <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_XFER: begin
                    if (xfer_done) begin
                        state <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        remaining <= remaining - 1'b1;
                        if (remaining == CNT_W'(1)) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: start request is a single-cycle pulse
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    // R3: no instruction can be taken while a transfer is being started
    p_busy_on_start_r3: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> !cmd_ready);

    // R4: chip selects move only on an accepted chip-select instruction
    p_cs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(accept && (instr.op == OP_CS)) |=> $stable(cs_n));

    // R8: sync event is a single-cycle pulse
    p_sync_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse);

    // R8: the sync ID only changes together with a sync event
    p_sync_id_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sync_pulse |-> $stable(sync_id));

endmodule

// File: tb/tb_spi_cmd_seq.sv
`timescale 1ns/1ps
module tb_spi_cmd_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [15:0] cmd_data;
    logic        cmd_ready;
    logic        xfer_start;
    logic [1:0]  xfer_flags;
    logic [7:0]  xfer_words_m1;
    logic        xfer_done;
    logic [7:0]  cs_n;
    logic [7:0]  cfg_clk_div;
    logic [7:0]  cfg_mode;
    logic [7:0]  cfg_word_bits;
    logic        sync_pulse;
    logic [7:0]  sync_id;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    spi_cmd_seq dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .xfer_start(xfer_start), .xfer_flags(xfer_flags),
        .xfer_words_m1(xfer_words_m1), .xfer_done(xfer_done), .cs_n(cs_n),
        .cfg_clk_div(cfg_clk_div), .cfg_mode(cfg_mode), .cfg_word_bits(cfg_word_bits),
        .sync_pulse(sync_pulse), .sync_id(sync_id)
    );

    // cmd, cs, div, mode, bits, sync id, pulse, stall cycles
    localparam int NV = 15;
    localparam logic [72:0] VEC [NV] = '{
        {16'h10FE, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'd0},
        {16'h2001, 8'hFE, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 16'd0},
        {16'h3102, 8'hFE, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 16'd12},
        {16'h137F, 8'h7F, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 16'd12},
        {16'h2103, 8'h7F, 8'h01, 8'h03, 8'h00, 8'h00, 1'b0, 16'd0},
        {16'h2210, 8'h7F, 8'h01, 8'h03, 8'h10, 8'h00, 1'b0, 16'd0},
        {16'h30A5, 8'h7F, 8'h01, 8'h03, 8'h10, 8'hA5, 1'b1, 16'd0},
        {16'h2577, 8'h7F, 8'h01, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd0},
        {16'h5123, 8'h7F, 8'h01, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd0},
        {16'h3744, 8'h7F, 8'h01, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd0},
        {16'h2000, 8'h7F, 8'h00, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd0},
        {16'h3100, 8'h7F, 8'h00, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd2},
        {16'h1201, 8'h01, 8'h00, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd4},
        {16'hFFFF, 8'h01, 8'h00, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd0},
        {16'h10FF, 8'hFF, 8'h00, 8'h03, 8'h10, 8'hA5, 1'b0, 16'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Waits for ready, offers one word, returns at the falling edge after acceptance.
    task automatic send(input logic [15:0] word);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = word;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data  = 16'h0000;
    endtask

    task automatic count_stall(output int stall);
        stall = 0;
        while (!cmd_ready) begin
            stall++;
            @(negedge clk);
        end
    endtask

    task automatic chk_reset_state(input string when);
        chk({"R1 cs_n ", when}, 32'(cs_n), 32'hFF);
        chk({"R1 cmd_ready ", when}, 32'(cmd_ready), 32'd1);
        chk({"R1 cfg ", when}, {8'h00, cfg_clk_div, cfg_mode, cfg_word_bits}, 32'h0);
        chk({"R1 sync_id ", when}, 32'(sync_id), 32'h0);
        chk({"R1 pulses ", when}, {30'd0, xfer_start, sync_pulse}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int stall;
        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_data = 16'h0000;
        xfer_done = 1'b0;
        repeat (3) @(negedge clk);
        chk_reset_state("in reset");
        rst = 1'b0;
        @(negedge clk);
        chk_reset_state("after reset");

        // R2 R3: read+write transfer of 16 words
        send(16'h030F);
        chk("R2 start pulse", 32'(xfer_start), 32'd1);
        chk("R2 flags", 32'(xfer_flags), 32'd3);
        chk("R2 words", 32'(xfer_words_m1), 32'h0F);
        chk("R3 busy at start", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        chk("R2 start one cycle", 32'(xfer_start), 32'd0);
        repeat (4) @(negedge clk);
        chk("R3 busy before done", 32'(cmd_ready), 32'd0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R3 ready after done", 32'(cmd_ready), 32'd1);

        // R2 R3: write-only single word
        send(16'h0100);
        chk("R2 start pulse wr", 32'(xfer_start), 32'd1);
        chk("R2 flags wr", 32'(xfer_flags), 32'd1);
        chk("R2 words wr", 32'(xfer_words_m1), 32'h00);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R3 ready after quick done", 32'(cmd_ready), 32'd1);

        // Table: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][72:57]);
            chk($sformatf("R4 cs_n vec %0d", i), 32'(cs_n), 32'(VEC[i][56:49]));
            chk($sformatf("R6 clk_div vec %0d", i), 32'(cfg_clk_div), 32'(VEC[i][48:41]));
            chk($sformatf("R6 mode vec %0d", i), 32'(cfg_mode), 32'(VEC[i][40:33]));
            chk($sformatf("R6 word_bits vec %0d", i), 32'(cfg_word_bits), 32'(VEC[i][32:25]));
            chk($sformatf("R8 sync_id vec %0d", i), 32'(sync_id), 32'(VEC[i][24:17]));
            chk($sformatf("R8 sync_pulse vec %0d", i), 32'(sync_pulse), 32'(VEC[i][16]));
            chk($sformatf("R9 no start vec %0d", i), 32'(xfer_start), 32'd0);
            count_stall(stall);
            chk($sformatf("R5 R7 stall vec %0d", i), 32'(stall), 32'(VEC[i][15:0]));
        end

        // R8: pulse is gone one cycle later
        send(16'h3033);
        chk("R8 id 33", 32'(sync_id), 32'h33);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(sync_pulse), 32'd0);

        // R9: unknown opcode leaves everything alone and takes no stall
        send(16'h8A5C);
        chk("R9 ready", 32'(cmd_ready), 32'd1);
        chk("R9 outputs", {cs_n, cfg_clk_div, sync_id, 6'd0, xfer_start, sync_pulse},
            {8'hFF, 8'h00, 8'h33, 8'h00});

        // R1: reset in the middle of a long sleep
        send(16'h1000);
        chk("R4 cs all low", 32'(cs_n), 32'h00);
        send(16'h31FF);
        repeat (5) @(negedge clk);
        chk("R7 sleeping", 32'(cmd_ready), 32'd0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_reset_state("mid sleep");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule